// File: doc/BRIEF.md
# Payload Alarm Substitution Controller

This block sits in a transmit serial payload path and decides, bit by bit, whether the outgoing payload is replaced by an alarm indication signal (an unframed all-ones stream). A 3-bit selector picks one of eight policies. Each policy combines line loopback, payload loopback, loss of signal and out-of-frame status, with diagnostic loopback able to veto some of them. Bits advance only on cycles where the clock enable is high.

The decision is held in a register that updates only on enabled cycles. The output therefore switches between payload and all ones only at a bit boundary, one enabled cycle after the condition changes. A flag output shows whether substitution is in force.

Top module: `ais_subst`

## Requirements
- R1: Selector 3'b000 substitutes all ones whatever the status inputs are.
- R2: Selector 3'b001 substitutes when line loopback is high and diagnostic loopback is low.
- R3: Selector 3'b010 substitutes when payload loopback is high.
- R4: Selector 3'b011 substitutes when payload loopback is high, or when line loopback is high with diagnostic loopback low.
- R5: Selector 3'b100 substitutes when loss of signal is high and diagnostic loopback is low.
- R6: Selector 3'b101 substitutes when out of frame is high.
- R7: Selector 3'b110 substitutes when any of these holds: out of frame high, payload loopback high, loss of signal high with diagnostic loopback low, or line loopback high with diagnostic loopback low.
- R8: Selector 3'b111 never substitutes.
- R9: The decision is captured on a rising clock edge with the enable high. After that edge, `ais_active` equals the decision and `dout` is 1 while `ais_active` is 1, otherwise `dout` equals `din`. With the enable low, `ais_active` holds its value.
- R10: Reset (active-low, asynchronous) clears `ais_active`, so `dout` follows `din`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Bit clock enable |
| mode | input | 3 | Substitution policy selector |
| line_lb | input | 1 | Line loopback active |
| diag_lb | input | 1 | Diagnostic loopback active |
| pay_lb | input | 1 | Payload loopback active |
| los | input | 1 | Loss of signal |
| oof | input | 1 | Out of frame |
| din | input | 1 | Incoming payload bit |
| dout | output | 1 | Outgoing payload bit or all ones |
| ais_active | output | 1 | Substitution in force |

## Verification
The block has no parameters, so the bench builds its only configuration. That configuration is small enough to sweep every selector value against all 32 status combinations. For each combination the bench checks the registered flag and the output with `din` at both levels. It also changes inputs with the enable low to confirm the decision holds until an enabled edge.

// File: rtl/ais_subst.sv
module ais_subst (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic [2:0] mode,
  input  logic       line_lb,
  input  logic       diag_lb,
  input  logic       pay_lb,
  input  logic       los,
  input  logic       oof,
  input  logic       din,
  output logic       dout,
  output logic       ais_active
);
  logic lb_q, los_q, want;

  assign lb_q  = line_lb & ~diag_lb;
  assign los_q = los & ~diag_lb;

  always_comb begin
    unique case (mode)
      3'b000:  want = 1'b1;
      3'b001:  want = lb_q;
      3'b010:  want = pay_lb;
      3'b011:  want = lb_q | pay_lb;
      3'b100:  want = los_q;
      3'b101:  want = oof;
      3'b110:  want = oof | los_q | lb_q | pay_lb;
      default: want = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      ais_active <= 1'b0;
    else if (bit_en) ais_active <= want;

  assign dout = ais_active | din;
endmodule

module ais_subst_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_en,
  input logic [2:0] mode,
  input logic       line_lb,
  input logic       diag_lb,
  input logic       pay_lb,
  input logic       los,
  input logic       oof,
  input logic       din,
  input logic       dout,
  input logic       ais_active
);
  p_always_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && mode == 3'b000) |=> ais_active);
  p_never_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && mode == 3'b111) |=> !ais_active);
  p_pay_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && mode == 3'b010) |=> (ais_active == $past(pay_lb)));
  p_oof_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && mode == 3'b101) |=> (ais_active == $past(oof)));
  p_diag_veto_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && mode == 3'b100 && diag_lb) |=> !ais_active);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(ais_active));
  p_ones_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ais_active |-> dout);
  always_comb
    if (rst_n && !ais_active) p_pass_r10: assert (dout == din);
endmodule

bind ais_subst ais_subst_chk chk_i (.*);

// File: tb/ais_subst_tb.sv
`timescale 1ns/1ps
module ais_subst_tb_top;
  logic clk = 0, rst_n = 0, bit_en = 0;
  logic [2:0] mode = 3'b111;
  logic line_lb = 0, diag_lb = 0, pay_lb = 0, los = 0, oof = 0, din = 0;
  logic dout, ais_active;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  ais_subst dut_i (.clk(clk), .rst_n(rst_n), .bit_en(bit_en), .mode(mode),
    .line_lb(line_lb), .diag_lb(diag_lb), .pay_lb(pay_lb), .los(los), .oof(oof),
    .din(din), .dout(dout), .ais_active(ais_active));

  function automatic logic model(input logic [2:0] m, input logic [4:0] s);
    logic l, d, p, lo, o, lq, sq;
    {l, d, p, lo, o} = s;
    lq = l & !d; sq = lo & !d;
    case (m)
      3'd0: return 1'b1;
      3'd1: return lq;
      3'd2: return p;
      3'd3: return lq | p;
      3'd4: return sq;
      3'd5: return o;
      3'd6: return o | sq | lq | p;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input logic act, input logic exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b mode=%0d st=%b", req, act, exp, mode,
               {line_lb, diag_lb, pay_lb, los, oof});
    end
  endtask

  function automatic string req_of(input logic [2:0] m);
    case (m)
      3'd0: return "R1"; 3'd1: return "R2"; 3'd2: return "R3"; 3'd3: return "R4";
      3'd4: return "R5"; 3'd5: return "R6"; 3'd6: return "R7"; default: return "R8";
    endcase
  endfunction

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog act=hang exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    mode = 3'b000;
    #20;
    chk(ais_active, 1'b0, "R10");
    din = 1; #1; chk(dout, 1'b1, "R10");
    din = 0; #1; chk(dout, 1'b0, "R10");
    @(negedge clk); rst_n = 1;
    for (int m = 0; m < 8; m++)
      for (int s = 0; s < 32; s++) begin
        logic e;
        @(negedge clk);
        mode = 3'(m);
        {line_lb, diag_lb, pay_lb, los, oof} = 5'(s);
        bit_en = 1;
        e = model(3'(m), 5'(s));
        @(negedge clk);
        bit_en = 0;
        chk(ais_active, e, req_of(3'(m)));
        din = 0; #1; chk(dout, e, "R9");
        din = 1; #1; chk(dout, 1'b1, "R9");
      end
    // hold with enable low (R9)
    @(negedge clk); mode = 3'b000; bit_en = 1;
    @(negedge clk); bit_en = 0; mode = 3'b111;
    @(negedge clk); @(negedge clk);
    chk(ais_active, 1'b1, "R9");
    bit_en = 1;
    @(negedge clk); bit_en = 0;
    chk(ais_active, 1'b0, "R9");
    din = 0; #1; chk(dout, 1'b0, "R9");
    // async reset clears (R10)
    @(negedge clk); mode = 3'b000; bit_en = 1;
    @(negedge clk); #1 rst_n = 0; #1;
    chk(ais_active, 1'b0, "R10");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule